// File: doc/BRIEF.md
# Instruction Address Compare Unit

This block watches the address of every instruction that is about to issue. It compares that address with four programmable compare registers and raises a debug event before the instruction executes. The registers form two pairs: registers 0/1 and registers 2/3. Each register can match one address exactly. A pair can instead be switched to range mode, where it matches addresses inside the window it spans, or addresses outside that window.

A single write port loads the four compare registers and one control register. Every hit sets a sticky status bit for each register involved, and a one-cycle event strobe goes with it. When debug interrupts are enabled, the full address of the matching instruction is captured. Software clears status bits by writing ones to a clear input.

Top module: `iac_unit`

## Requirements
- R1: After reset, the status bits, the event strobe, the captured address, all compare registers and the control register are zero. An instruction that arrives with that state produces no event.
- R2: A write with `wrSel` 0 to 3 loads compare register `wrSel`. A write with `wrSel` = 4 loads the control register from `wrData[7:0]`. Control bits [3:0] enable registers 0 to 3. Bit 4 puts pair 0/1 in range mode and bit 5 does the same for pair 2/3. Bit 6 selects outside matching for pair 0/1 and bit 7 does the same for pair 2/3. A compare that happens in the same cycle as a write uses the old values.
- R3: In exact mode, a valid instruction whose address bits [31:2] equal those of an enabled register sets that register's status bit one cycle later. Several registers may hit on the same instruction.
- R4: Address bits [1:0] are ignored in every comparison, both for the instruction address and for the register value.
- R5: In inside-range mode, with the lower register's enable bit set, a pair hits when lowReg <= addr < highReg (lowReg is register 0 or 2). A hit sets both status bits of the pair.
- R6: In outside-range mode, a pair hits exactly when the inside condition of R5 is false. A hit sets both status bits of the pair.
- R7: While a pair is in range mode, neither of its registers performs an exact match. The enable bit of the upper register has no effect in that mode.
- R8: `eventPulse` is high for exactly the one cycle after an instruction that hits at least one register, and low otherwise.
- R9: If `dbgIntEn` is high with a hitting instruction, `capAddr` holds that instruction's full 32-bit address one cycle later. Otherwise `capAddr` keeps its value.
- R10: Status bits stay set until a 1 is written on the matching `stsClr` bit. A new hit in the same cycle as a clear leaves the bit set.
- R11: When `instValid` is low, no status bit is set and no event is raised, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for compare and control registers |
| wrSel | input | 3 | Write target: 0 to 3 compare registers, 4 control |
| wrData | input | 32 | Write data |
| stsClr | input | 4 | Write-one-to-clear for status bits |
| instValid | input | 1 | An instruction is about to execute |
| instAddr | input | 32 | Address of that instruction |
| dbgIntEn | input | 1 | Debug interrupts enabled; allows address capture |
| status | output | 4 | Sticky per-register hit bits |
| eventPulse | output | 1 | One-cycle debug event strobe |
| capAddr | output | 32 | Address of the last captured matching instruction |

## Verification
Status, `eventPulse` and `capAddr` all come from registers loaded at the clock edge that samples the instruction. Each result is therefore due exactly one cycle after the stimulus is applied. The driver applies each stimulus on a falling edge and pushes the predicted outputs onto a queue. The monitor takes one item after each rising edge and compares it, so every prediction is matched to the first edge that can produce it. The predictions come from a model of the control bits and compare registers written in the bench. Writes update that model only after the compare for the same cycle, so compares see the old values. The range boundaries, same-cycle clear against set, and disabled exact matching in range mode each have their own stimulus.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int CMP_N   = 4;
  localparam int PAIR_N  = CMP_N / 2;
  localparam int ADDR_W  = 32;
  localparam int IGN_LSB = 2;
  localparam int CTRL_W  = CMP_N + 2 * PAIR_N;
  localparam int SEL_W   = $clog2(CMP_N + 1);

  typedef struct packed {
    logic [CMP_N-1:0] cmpLoad;
    logic             capture;
  } iacStrobe_t;
endpackage

// File: rtl/iac_datapath.sv
module iac_datapath
  import iac_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  iacStrobe_t                strobe,
  input  logic [ADDR_W-1:IGN_LSB]   wrWord,
  input  logic [ADDR_W-1:0]         instAddr,
  output logic [CMP_N-1:0]          exactEq,
  output logic [PAIR_N-1:0]         pairIn,
  output logic [ADDR_W-1:0]         capAddr
);
  logic [ADDR_W-1:IGN_LSB] cmpReg [CMP_N];
  logic [ADDR_W-1:IGN_LSB] addrWord;

  assign addrWord = instAddr[ADDR_W-1:IGN_LSB];

  for (genvar i = 0; i < CMP_N; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rstN) cmpReg[i] <= '0;
      else if (strobe.cmpLoad[i]) cmpReg[i] <= wrWord;
    end
    assign exactEq[i] = (addrWord == cmpReg[i]);
  end

  for (genvar p = 0; p < PAIR_N; p++) begin : g_range
    assign pairIn[p] = (addrWord >= cmpReg[2*p]) && (addrWord < cmpReg[2*p+1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) capAddr <= '0;
    else if (strobe.capture) capAddr <= instAddr;
  end

  // R9: capture register only moves on a capture strobe
  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(capAddr));
  p_cap_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (capAddr == $past(instAddr)));
endmodule

// File: rtl/iac_ctrl.sv
module iac_ctrl
  import iac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [CTRL_W-1:0]  wrCtrl,
  input  logic [CMP_N-1:0]   stsClr,
  input  logic               instValid,
  input  logic               dbgIntEn,
  input  logic [CMP_N-1:0]   exactEq,
  input  logic [PAIR_N-1:0]  pairIn,
  output iacStrobe_t         strobe,
  output logic [CMP_N-1:0]   status,
  output logic               eventPulse
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [CMP_N-1:0]  enBits;
  logic [PAIR_N-1:0] rangeBits;
  logic [PAIR_N-1:0] outBits;
  logic [CMP_N-1:0]  hitVec;
  logic [CMP_N-1:0]  loadVec;

  assign enBits    = ctrlReg[CMP_N-1:0];
  assign rangeBits = ctrlReg[CMP_N +: PAIR_N];
  assign outBits   = ctrlReg[CMP_N+PAIR_N +: PAIR_N];

  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    logic pairHit;
    assign pairHit = instValid & enBits[2*p] & (pairIn[p] ^ outBits[p]);
    for (genvar k = 0; k < 2; k++) begin : g_reg
      localparam int IDX = 2 * p + k;
      assign hitVec[IDX] = rangeBits[p] ? pairHit
                                        : (instValid & enBits[IDX] & exactEq[IDX]);
    end
  end

  for (genvar i = 0; i < CMP_N; i++) begin : g_load
    assign loadVec[i] = wrEn && (wrSel == SEL_W'(i));
  end

  always_comb begin
    strobe.cmpLoad = loadVec;
    strobe.capture = (|hitVec) & dbgIntEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      status     <= '0;
      eventPulse <= 1'b0;
    end else begin
      if (wrEn && (wrSel == SEL_W'(CMP_N))) ctrlReg <= wrCtrl;
      status     <= (status & ~stsClr) | hitVec;
      eventPulse <= |hitVec;
    end
  end

  // R8: an event always comes with at least one status bit
  p_event_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> (status != '0));
  // R10: without a clear, no status bit falls
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stsClr == '0) |=> ((status & $past(status)) == $past(status)));
  // R10: a hit wins over a clear in the same cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |=> ((status & $past(hitVec)) == $past(hitVec)));
  // R11: no instruction, no event
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !eventPulse);
endmodule

// File: rtl/iac_unit.sv
module iac_unit
  import iac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     wrSel,
  input  logic [ADDR_W-1:0]    wrData,
  input  logic [CMP_N-1:0]     stsClr,
  input  logic                 instValid,
  input  logic [ADDR_W-1:0]    instAddr,
  input  logic                 dbgIntEn,
  output logic [CMP_N-1:0]     status,
  output logic                 eventPulse,
  output logic [ADDR_W-1:0]    capAddr
);
  iacStrobe_t        strobe;
  logic [CMP_N-1:0]  exactEq;
  logic [PAIR_N-1:0] pairIn;

  iac_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrCtrl     (wrData[CTRL_W-1:0]),
    .stsClr     (stsClr),
    .instValid  (instValid),
    .dbgIntEn   (dbgIntEn),
    .exactEq    (exactEq),
    .pairIn     (pairIn),
    .strobe     (strobe),
    .status     (status),
    .eventPulse (eventPulse)
  );

  iac_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrWord   (wrData[ADDR_W-1:IGN_LSB]),
    .instAddr (instAddr),
    .exactEq  (exactEq),
    .pairIn   (pairIn),
    .capAddr  (capAddr)
  );
endmodule

// File: tb/iac_unit_tb_top.sv
module iac_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  stsClr = '0;
  logic        instValid = 1'b0;
  logic [31:0] instAddr = '0;
  logic        dbgIntEn = 1'b0;
  logic [3:0]  status;
  logic        eventPulse;
  logic [31:0] capAddr;

  iac_unit dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [3:0]  st;
    logic        ev;
    logic [31:0] cap;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the programmable state
  logic [31:0] cmpM [4];
  logic [7:0]  ctrlM = '0;
  logic [3:0]  stM = '0;
  logic [31:0] capM = '0;

  function automatic logic [3:0] modelHits(logic v, logic [31:0] a);
    logic [3:0] h = '0;
    for (int p = 0; p < 2; p++) begin
      if (ctrlM[4+p]) begin
        logic inR;
        inR = (a[31:2] >= cmpM[2*p][31:2]) && (a[31:2] < cmpM[2*p+1][31:2]);
        if (v && ctrlM[2*p] && (ctrlM[6+p] ? !inR : inR)) h[2*p +: 2] = 2'b11;
      end else begin
        for (int k = 0; k < 2; k++)
          if (v && ctrlM[2*p+k] && (a[31:2] == cmpM[2*p+k][31:2])) h[2*p+k] = 1'b1;
      end
    end
    return h;
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic dbg,
                      input logic [3:0] clr, input logic we, input logic [2:0] sel,
                      input logic [31:0] d, input string tag);
    logic [3:0] h;
    exp_t e;
    @(negedge clk);
    instValid = v; instAddr = a; dbgIntEn = dbg; stsClr = clr;
    wrEn = we; wrSel = sel; wrData = d;
    h = modelHits(v, a);
    stM = (stM & ~clr) | h;
    if ((h != 0) && dbg) capM = a;
    if (we) begin
      if (sel < 4) cmpM[sel] = d;
      else if (sel == 4) ctrlM = d[7:0];
    end
    e.st = stM; e.ev = (h != 0); e.cap = capM; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d, input string tag);
    step(1'b0, 32'h0, 1'b0, 4'h0, 1'b1, sel, d, tag);
  endtask

  task automatic ex(input logic [31:0] a, input logic dbg, input string tag);
    step(1'b1, a, dbg, 4'h0, 1'b0, 3'd0, 32'h0, tag);
  endtask

  task automatic clrAll();
    step(1'b0, 32'h0, 1'b0, 4'hF, 1'b0, 3'd0, 32'h0, "R10");
  endtask

  // monitor: compares each prediction one cycle after its stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks += 3;
        if (status !== e.st) begin
          fails++;
          $display("FAIL %s status got %b expected %b", e.tag, status, e.st);
        end
        if (eventPulse !== e.ev) begin
          fails++;
          $display("FAIL R8 (%s) event got %b expected %b", e.tag, eventPulse, e.ev);
        end
        if (capAddr !== e.cap) begin
          fails++;
          $display("FAIL R9 (%s) capAddr got %h expected %h", e.tag, capAddr, e.cap);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) cmpM[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, and an instruction at zero with all enables off
    step(1'b0, 32'h0, 1'b0, 4'h0, 1'b0, 3'd0, 32'h0, "R1");
    ex(32'h0, 1'b1, "R1");
    // R2: program registers and control
    wr(3'd0, 32'h0000_1000, "R2");
    wr(3'd1, 32'h0000_2000, "R2");
    wr(3'd2, 32'h0000_3000, "R2");
    wr(3'd3, 32'h0000_3000, "R2");
    wr(3'd4, 32'h0000_0003, "R2");
    // R3: exact hits
    ex(32'h0000_1000, 1'b1, "R3");
    ex(32'h0000_2000, 1'b1, "R3");
    // R4 and R10: low bits ignored, set wins over clear, other bit cleared
    step(1'b1, 32'h0000_1003, 1'b1, 4'h3, 1'b0, 3'd0, 32'h0, "R4");
    clrAll();
    ex(32'h0000_1004, 1'b1, "R4");
    // R2: write and compare in the same cycle uses old value
    step(1'b1, 32'h0000_1000, 1'b1, 4'h0, 1'b1, 3'd0, 32'h0000_1003, "R2");
    ex(32'h0000_1000, 1'b1, "R4");
    clrAll();
    // R3 and R9: two registers at once, no capture without debug interrupts
    wr(3'd4, 32'h0000_000F, "R2");
    ex(32'h0000_3000, 1'b0, "R3");
    step(1'b0, 32'h0, 1'b0, 4'h0, 1'b0, 3'd0, 32'h0, "R10");
    // R11: invalid instruction at a matching address
    step(1'b0, 32'h0000_3000, 1'b1, 4'h0, 1'b0, 3'd0, 32'h0, "R11");
    clrAll();
    // R5: inside range on pair 0/1
    wr(3'd4, 32'h0000_0011, "R2");
    ex(32'h0000_1000, 1'b1, "R5");
    clrAll();
    ex(32'h0000_1FFC, 1'b1, "R5");
    clrAll();
    ex(32'h0000_2000, 1'b1, "R5");
    ex(32'h0000_0FFC, 1'b1, "R5");
    // R7: upper register exact match suppressed in range mode
    wr(3'd4, 32'h0000_0013, "R2");
    ex(32'h0000_2000, 1'b1, "R7");
    // R6: outside range
    wr(3'd4, 32'h0000_0051, "R2");
    ex(32'h0000_2000, 1'b1, "R6");
    clrAll();
    ex(32'h0000_1800, 1'b1, "R6");
    ex(32'h0000_0FFC, 1'b1, "R6");
    clrAll();
    // R7: upper enable alone does nothing in range mode
    wr(3'd4, 32'h0000_0012, "R2");
    ex(32'h0000_1800, 1'b1, "R7");
    // R7: pair 2/3 in range mode with an empty window, exact disabled
    wr(3'd4, 32'h0000_002C, "R2");
    ex(32'h0000_3000, 1'b1, "R7");
    step(1'b0, 32'h0, 1'b0, 4'h0, 1'b0, 3'd0, 32'h0, "R11");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule